// File: doc/BRIEF.md
# Bit Scan Forward/Reverse Unit

This unit finds the first set bit of a 16-bit or 32-bit source word and reports its position. In upward mode the search starts at bit 0 and returns the lowest set bit. In downward mode it starts at the top bit of the operand and returns the highest set bit. A caller presents the word, the direction and the operand size together with a one-cycle start strobe. One clock later the unit writes the index into its destination register, updates a found flag and raises a done pulse.

If the scanned bits are all zero, the flag is cleared and the destination register keeps whatever it held before. A caller can therefore tell an empty operand from a hit at bit 0. For 16-bit operands the upper half of the source is ignored. The index is always zero-extended to the full destination width.

The request side is a plain strobe, not a valid/ready pair. The unit accepts a new request on every clock, so it never applies back-pressure. Each start produces exactly one done pulse, one cycle later.

Top module: `bscan_unit`

## Requirements
- R1: With dir_i = 0 (upward), the index written is that of the lowest set bit of the scanned operand (e.g. 0x00000001 gives 0, 0x00003000 gives 12).
- R2: With dir_i = 1 (downward), the index written is that of the highest set bit of the scanned operand (e.g. 0x80000000 at 32 bits gives 31, 0x00FF at 16 bits gives 7).
- R3: When the scanned operand has at least one set bit, found_o becomes 1 and dest_o takes the index.
- R4: When the scanned operand is all zero, found_o becomes 0 and dest_o keeps its previous value.
- R5: With wide_i = 0 (16-bit), only src_i[15:0] is scanned and src_i[31:16] has no effect. With wide_i = 1 all 32 bits are scanned. The index is zero-extended into dest_o, so a 16-bit scan never writes a value above 15.
- R6: dest_o, found_o and done_o change only in the cycle after a start. done_o is high for exactly that one cycle per start, and with start_i low the outputs hold.
- R7: After reset, dest_o, found_o and done_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, one cycle per scan |
| dir_i | input | 1 | 0 = scan upward from bit 0, 1 = scan downward from the top bit |
| wide_i | input | 1 | 0 = 16-bit operand, 1 = 32-bit operand |
| src_i | input | 32 | Source word |
| dest_o | output | 32 | Destination register holding the found index |
| found_o | output | 1 | 1 when the last scan found a set bit |
| done_o | output | 1 | One-cycle pulse the cycle after a start |

## Verification
Single-bit words at the extremes (bit 0, bit 15, bit 31) separate the two directions only when combined with words that have several bits set, such as 0x3000 and 0x00FF, where the lowest and highest positions differ. All-zero words, and 16-bit requests whose set bits lie only in the upper half, show that the destination is held and not cleared, and that the operand size masks correctly. Random words with a random direction and size, interleaved with idle cycles, cover sparse and dense patterns and confirm that nothing moves without a start.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NARROW_W = 16;

  typedef enum logic {
    SCAN_UP   = 1'b0,
    SCAN_DOWN = 1'b1
  } scan_dir_e;

  typedef enum logic {
    OPSZ_HALF = 1'b0,
    OPSZ_FULL = 1'b1
  } op_size_e;
endpackage

// File: rtl/bscan_mask.sv
module bscan_mask #(
  parameter int unsigned W  = 32,
  parameter int unsigned NW = 16
) (
  input  logic         wide,
  input  logic [W-1:0] src,
  output logic [W-1:0] masked
);
  localparam int unsigned HI_W = W - NW;

  generate
    if (HI_W == 0) begin : g_same
      assign masked = src;
    end else begin : g_split
      assign masked = wide ? src : {{HI_W{1'b0}}, src[NW-1:0]};
    end
  endgenerate
endmodule

// File: rtl/bscan_prio.sv
module bscan_prio #(
  parameter int unsigned W       = 32,
  parameter int unsigned IW      = 5,
  parameter bit          HIGHEST = 1'b0
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  assign any = |vec;

  generate
    if (HIGHEST) begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
          if (vec[i]) idx = IW'(i);
        end
      end
    end else begin : g_low
      always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
          if (vec[i]) idx = IW'(i);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bscan_unit.sv
module bscan_unit
  import bscan_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned NW = NARROW_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         dir_i,
  input  logic         wide_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] dest_o,
  output logic         found_o,
  output logic         done_o
);
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

  scan_dir_e     dir;
  op_size_e      opsz;
  logic [W-1:0]  scan_vec;
  logic [IW-1:0] idx_lo, idx_hi, idx_sel;
  logic          any_lo, any_hi;

  assign dir  = scan_dir_e'(dir_i);
  assign opsz = op_size_e'(wide_i);

  bscan_mask #(.W(W), .NW(NW)) u_mask (
    .wide   (opsz == OPSZ_FULL),
    .src    (src_i),
    .masked (scan_vec)
  );

  bscan_prio #(.W(W), .IW(IW), .HIGHEST(1'b0)) u_low (
    .vec (scan_vec),
    .idx (idx_lo),
    .any (any_lo)
  );

  bscan_prio #(.W(W), .IW(IW), .HIGHEST(1'b1)) u_high (
    .vec (scan_vec),
    .idx (idx_hi),
    .any (any_hi)
  );

  assign idx_sel = (dir == SCAN_DOWN) ? idx_hi : idx_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_o  <= '0;
      found_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        found_o <= any_lo;
        if (any_hi) dest_o <= W'(idx_sel);
      end
    end
  end

  // R6: one done pulse follows each start
  p_done_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  p_no_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !done_o);
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(dest_o) && $stable(found_o)));
  // R3: nonzero operand raises the flag
  p_found_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (|scan_vec)) |=> found_o);
  // R4: zero operand clears the flag and keeps the destination
  p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !(|src_i)) |=> (!found_o && $stable(dest_o)));
  // R5: a 16-bit hit never reports an index above the narrow width
  p_narrow_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !wide_i && (|src_i[NW-1:0])) |=> (dest_o < W'(NW)));
  // R2/R1: the downward index is never below the upward one
  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && any_lo) |-> (idx_hi >= idx_lo));
endmodule

// File: tb/sim_bscan_unit.sv
`timescale 1ns/1ps
module sim_bscan_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        dir_i = 1'b0;
  logic        wide_i = 1'b0;
  logic [31:0] src_i = '0;
  logic [31:0] dest_o;
  logic        found_o;
  logic        done_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] m_dest = '0;
  logic        m_found = 1'b0;

  always #5 clk = ~clk;

  bscan_unit u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
    .wide_i(wide_i), .src_i(src_i), .dest_o(dest_o),
    .found_o(found_o), .done_o(done_o)
  );

  function automatic logic [31:0] lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic [31:0] highest(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic scan(input string req, input logic d, input logic w, input logic [31:0] s);
    logic [31:0] v;
    @(negedge clk);
    start_i = 1'b1; dir_i = d; wide_i = w; src_i = s;
    v = w ? s : {16'h0, s[15:0]};
    if (v != 0) begin
      m_found = 1'b1;
      m_dest = d ? highest(v) : lowest(v);
    end else begin
      m_found = 1'b0;
    end
    @(negedge clk);
    start_i = 1'b0;
    src_i = $urandom;
    chk({req, " dest"}, dest_o, m_dest);
    chk({req, " found"}, {31'b0, found_o}, {31'b0, m_found});
    chk("R6 done", {31'b0, done_o}, 32'd1);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R6 idle done", {31'b0, done_o}, 32'd0);
    chk("R6 idle dest", dest_o, m_dest);
    chk("R6 idle found", {31'b0, found_o}, {31'b0, m_found});
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R7 dest", dest_o, 32'd0);
    chk("R7 found", {31'b0, found_o}, 32'd0);
    chk("R7 done", {31'b0, done_o}, 32'd0);
    rst_n = 1'b1;
    idle_check();
    scan("R1", 1'b0, 1'b1, 32'h0000_0001);
    scan("R1", 1'b0, 1'b1, 32'h0000_3000);
    scan("R5 R1", 1'b0, 1'b0, 32'h0000_00FF);
    scan("R2", 1'b1, 1'b0, 32'h0000_00FF);
    scan("R4", 1'b1, 1'b0, 32'h0000_0000);
    idle_check();
    scan("R2", 1'b1, 1'b1, 32'h8000_0000);
    scan("R5 R4", 1'b0, 1'b0, 32'hFFFF_0000);
    scan("R1", 1'b0, 1'b1, 32'h8000_0000);
    scan("R5 R2", 1'b1, 1'b0, 32'h8001_8000);
    scan("R3", 1'b1, 1'b1, 32'hFFFF_FFFF);
    scan("R4", 1'b0, 1'b1, 32'h0000_0000);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] s;
      s = $urandom;
      case ($urandom % 4)
        0: s = s & $urandom & $urandom;
        1: s = 32'h1 << ($urandom % 32);
        2: s = ($urandom % 3 == 0) ? 32'h0 : s;
        default: ;
      endcase
      scan("R3", 1'($urandom), 1'($urandom), s);
      if ($urandom % 5 == 0) idle_check();
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule